// File: doc/BRIEF.md
# SSI Position Word Transmitter

This block is the sensor end of a Synchronous Serial Interface link. A controller drives a clock line; the block follows it from a much faster system clock. It passes that line through a two-stage synchronizer and picks out the rising and falling edges in the system domain. The first falling edge of a clock burst captures the current position into a holding register. The captured word is converted to Gray code at that moment if the strap asks for it. Each later rising edge puts the next bit on the data line, most significant bit first. A word of n bits therefore takes n+1 clock pulses.

After the burst a monoflop timer, counted in system clocks, sets how long the line stays low before it returns high and a new burst can begin. Every falling edge restarts the timer. This covers bursts with too few edges: the last bit is held, then the line is released. It also covers bursts with too many edges: the line stays low and the timer keeps being re-armed. A busy output marks the span from the trigger edge until the timer runs out.

Top module: `ssi_pos_tx`

## Requirements
- R1: Out of reset and whenever the block is idle, `ssi_data` is 1 and `busy` is 0.
- R2: A falling edge of `ssi_clk_in` while idle captures the position word and sets `busy`. `ssi_data` stays 1 until the first rising edge. Each line edge appears at the outputs three system clocks after it is sampled.
- R3: Each rising edge after the trigger drives the next bit of the captured word onto `ssi_data`, starting at bit WORD_W-1 and ending at bit 0.
- R4: The rising edge that follows the last bit, which is pulse WORD_W+1, drives `ssi_data` to 0. It stays 0 while `busy` is 1.
- R5: The block returns to idle (`ssi_data`=1, `busy`=0) MONO_CYC system clocks after the last falling edge is detected.
- R6: If a burst stops early, the last driven bit is held until the timer expires. A rising edge that arrives before expiry drives the next bit, so a paused burst still delivers the whole word.
- R7: If a burst has extra pulses, extra rising edges leave `ssi_data` at 0. Each extra falling edge restarts the full MONO_CYC interval.
- R8: `gray_en`=1 captures the Gray code of the value, which is the value XOR the value shifted right by one. `gray_en`=0 captures plain binary.
- R9: `pos_in` is signed, and its bit WORD_W is the sign. A negative value is captured as all ones in WORD_W bits, before any Gray conversion.
- R10: A falling edge detected in the same cycle the timer would expire restarts the timer. The line neither returns high nor leaves the low state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssi_clk_in | input | 1 | SSI clock from the controller, asynchronous, high when idle |
| pos_in | input | WORD_W+1 | Signed position value; bit WORD_W is the sign |
| gray_en | input | 1 | 1 = Gray coded output, 0 = binary |
| ssi_data | output | 1 | Serial data line |
| busy | output | 1 | High from the trigger edge until the monoflop expires |

## Verification
Two functions can fall on the same system cycle. One is the expiry of the monoflop, which returns the line to idle. The other is a newly detected falling edge, which restarts the timer. The bench provokes the collision after a full burst: it drives a fresh falling edge exactly MONO_CYC clocks after the previous one, so that its detection lands on the expiry cycle. A cycle-accurate behavioural model decides that the restart wins. The bench then compares the line and `busy` on every clock, and also checks that the release comes a full interval after the colliding edge.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } ssi_st_e;

endpackage

// File: rtl/ssi_edge_det.sv
module ssi_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign rise_o =  sync_q[DEPTH-2] & ~sync_q[DEPTH-1];
    assign fall_o = ~sync_q[DEPTH-2] &  sync_q[DEPTH-1];

endmodule

// File: rtl/ssi_word_prep.sv
module ssi_word_prep #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W:0]   pos_in,
    input  logic              gray_en,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] bin_w;
    logic [WORD_W-1:0] gray_w;

    // negative input wraps to the top code
    assign bin_w = pos_in[WORD_W] ? '1 : pos_in[WORD_W-1:0];

    assign gray_w[WORD_W-1] = bin_w[WORD_W-1];
    for (genvar i = 0; i < WORD_W - 1; i++) begin : g_gray
        assign gray_w[i] = bin_w[i] ^ bin_w[i+1];
    end

    assign word_o = gray_en ? gray_w : bin_w;

endmodule

// File: rtl/ssi_mono_timer.sv
module ssi_mono_timer #(
    parameter int MONO_CYC = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(MONO_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(MONO_CYC);

    logic [CNT_W-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart_i)          tmr_d = LOAD;
        else if (tmr_q != '0)   tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire_o = (tmr_q == CNT_W'(1)) && !restart_i;

    // R10: a restart always reloads the full interval, even on the expiry cycle
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (tmr_q == LOAD));

    // R5: expiry leaves the timer stopped
    p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (tmr_q == '0));

endmodule

// File: rtl/ssi_pos_tx.sv
module ssi_pos_tx
    import ssi_tx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int MONO_CYC = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssi_clk_in,
    input  logic [WORD_W:0]   pos_in,
    input  logic              gray_en,
    output logic              ssi_data,
    output logic              busy
);
    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W);

    if (!(WORD_W == 16 || WORD_W == 18 || WORD_W == 20)) begin : g_bad_width
        $error("ssi_pos_tx: WORD_W must be 16, 18 or 20");
    end

    typedef struct packed {
        ssi_st_e           st;
        logic [WORD_W-1:0] sh;
        logic [BIT_W-1:0]  nbits;
        logic              data;
        logic              busy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rise_w, fall_w, expire_w;
    logic [WORD_W-1:0] word_w;

    ssi_edge_det #(.SYNC_STAGES(2)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ssi_clk_in),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    ssi_word_prep #(.WORD_W(WORD_W)) i_prep (
        .pos_in  (pos_in),
        .gray_en (gray_en),
        .word_o  (word_w)
    );

    ssi_mono_timer #(.MONO_CYC(MONO_CYC)) i_mono (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (fall_w),
        .expire_o  (expire_w)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.data = 1'b1;
                ctl_d.busy = 1'b0;
                if (fall_w) begin
                    ctl_d.st    = ST_SHIFT;
                    ctl_d.sh    = word_w;
                    ctl_d.nbits = '0;
                    ctl_d.busy  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (expire_w) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.data = 1'b1;
                    ctl_d.busy = 1'b0;
                end else if (rise_w) begin
                    if (ctl_q.nbits == LAST_BIT) begin
                        ctl_d.st   = ST_TAIL;
                        ctl_d.data = 1'b0;
                    end else begin
                        ctl_d.data  = ctl_q.sh[WORD_W-1];
                        ctl_d.sh    = {ctl_q.sh[WORD_W-2:0], 1'b0};
                        ctl_d.nbits = ctl_q.nbits + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (expire_w) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.data = 1'b1;
                    ctl_d.busy = 1'b0;
                end
            end
            default: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.data = 1'b1;
                ctl_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.sh    <= '0;
            ctl_q.nbits <= '0;
            ctl_q.data  <= 1'b1;
            ctl_q.busy  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ssi_data = ctl_q.data;
    assign busy     = ctl_q.busy;

    // R1: idle state always shows a released line
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !$past(ctl_q.st == ST_IDLE && fall_w)) |-> (ssi_data && !busy));

    // R2: trigger raises busy while the line stays high
    p_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && fall_w) |=> (busy && ssi_data && ctl_q.st == ST_SHIFT));

    // R3: a shifting rise puts the previously leading bit on the line
    p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SHIFT && rise_w && !expire_w && ctl_q.nbits != LAST_BIT)
        |=> (ssi_data == $past(ctl_q.sh[WORD_W-1])));

    // R4: the tail keeps the line low
    p_tail_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TAIL) |-> (!ssi_data && busy));

    // R5: expiry releases the line
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w |=> (ssi_data && !busy));

    // R6: without a rise or expiry the line level holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE && !rise_w && !expire_w) |=> $stable(ssi_data));

    // R7: extra rises in the tail change nothing
    p_overclock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TAIL && rise_w && !expire_w) |=> (ctl_q.st == ST_TAIL && !ssi_data));

endmodule

// File: tb/test_ssi_pos_tx.sv
module test_ssi_pos_tx;
    localparam int WORD_W   = 16;
    localparam int MONO_CYC = 800;
    localparam int HALF     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ssi_clk = 1'b1;
    logic [WORD_W:0]   pos_in = '0;
    logic              gray_en = 1'b0;
    logic              ssi_data, busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_fall = 0;
    bit done   = 0;
    bit cmp_en = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    ssi_pos_tx #(.WORD_W(WORD_W), .MONO_CYC(MONO_CYC)) i_ssi_pos_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ssi_clk_in (ssi_clk),
        .pos_in     (pos_in),
        .gray_en    (gray_en),
        .ssi_data   (ssi_data),
        .busy       (busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [WORD_W-1:0] exp_word(input logic [WORD_W:0] p, input logic g);
        logic [WORD_W-1:0] b, r;
        b = p[WORD_W] ? {WORD_W{1'b1}} : p[WORD_W-1:0];
        r = b;
        if (g) for (int i = 0; i < WORD_W - 1; i++) r[i] = b[i] ^ b[i+1];
        return r;
    endfunction

    // behavioural reference: sees the line with a two-clock lag
    logic              hist[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
    int                m_st = 0;
    int                m_tmr = 0;
    int                m_cnt = 0;
    logic              m_data = 1'b1;
    logic              m_busy = 1'b0;
    logic [WORD_W-1:0] m_word = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            hist = '{1'b1, 1'b1, 1'b1, 1'b1};
            m_st = 0; m_tmr = 0; m_cnt = 0; m_data = 1'b1; m_busy = 1'b0;
        end else begin
            bit f, r, ex;
            hist.push_front(ssi_clk);
            hist.delete(4);
            f  = hist[3] && !hist[2];
            r  = !hist[3] && hist[2];
            ex = (m_tmr == 1) && !f;
            if (f) begin
                if (m_st == 0) begin
                    m_word = exp_word(pos_in, gray_en);
                    m_cnt = 0; m_st = 1; m_busy = 1'b1;
                end
                m_tmr = MONO_CYC;
            end else begin
                if (m_tmr > 0) m_tmr--;
                if (ex) begin
                    m_st = 0; m_data = 1'b1; m_busy = 1'b0;
                end else if (r && m_st == 1) begin
                    if (m_cnt == WORD_W) begin
                        m_data = 1'b0; m_st = 2;
                    end else begin
                        m_data = m_word[WORD_W-1-m_cnt];
                        m_cnt++;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            chk({cur_tag, " line"}, 32'(ssi_data), 32'(m_data));
            chk({cur_tag, " busy"}, 32'(busy), 32'(m_busy));
        end
    end

    task automatic burst(input int npulse, input int pause_after, input int pause_len,
                         output logic [WORD_W-1:0] got);
        got = '0;
        for (int i = 0; i < npulse; i++) begin
            ssi_clk = 1'b0;
            last_fall = cyc;
            repeat (HALF) @(negedge clk);
            ssi_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < WORD_W)       got[WORD_W-1-i] = ssi_data;
            else if (i == WORD_W) chk("R4 tail low", 32'(ssi_data), 32'd0);
            else                  chk("R7 extra pulse", 32'(ssi_data), 32'd0);
            if (i + 1 == pause_after) repeat (pause_len) @(negedge clk);
        end
    endtask

    task automatic wait_idle(input string tag);
        while (busy) @(negedge clk);
        chk({tag, " release delay"}, 32'(cyc - last_fall), 32'(MONO_CYC + 3));
        chk({tag, " line high"}, 32'(ssi_data), 32'd1);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        logic [WORD_W-1:0] got;
        logic [WORD_W-1:0] ew;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (5) @(negedge clk);
        cur_tag = "R1";
        chk("R1 reset line", 32'(ssi_data), 32'd1);
        chk("R1 reset busy", 32'(busy), 32'd0);

        // R2 R3 R4 R5: nominal binary burst
        cur_tag = "R3";
        pos_in = 17'h0A5C3; gray_en = 1'b0;
        ssi_clk = 1'b0; last_fall = cyc;
        repeat (4) @(negedge clk);
        chk("R2 busy after trigger", 32'(busy), 32'd1);
        chk("R2 line high before first rise", 32'(ssi_data), 32'd1);
        ssi_clk = 1'b1;
        repeat (4) @(negedge clk);
        repeat (HALF - 4) @(negedge clk);
        got = '0; got[WORD_W-1] = ssi_data;
        begin
            logic [WORD_W-1:0] rest;
            burst(WORD_W, 0, 0, rest);
            got[WORD_W-2:0] = rest[WORD_W-1:1];
            chk("R4 tail low", 32'(ssi_data), 32'd0);
        end
        chk("R3 binary word", 32'(got), 32'(exp_word(17'h0A5C3, 1'b0)));
        wait_idle("R5");

        // R8: Gray word
        cur_tag = "R8";
        pos_in = 17'h01234; gray_en = 1'b1;
        burst(WORD_W + 1, 0, 0, got);
        chk("R8 gray word", 32'(got), 32'(exp_word(17'h01234, 1'b1)));
        wait_idle("R8");

        // R9: negative value wraps to all ones
        cur_tag = "R9";
        pos_in = 17'h1FFFB; gray_en = 1'b0;
        burst(WORD_W + 1, 0, 0, got);
        chk("R9 negative wrap", 32'(got), 32'hFFFF);
        wait_idle("R9");

        // R6: short burst, hold then release
        cur_tag = "R6";
        pos_in = 17'h08041; gray_en = 1'b0;
        ew = exp_word(17'h08041, 1'b0);
        burst(9, 0, 0, got);
        chk("R6 partial bits", 32'(got >> (WORD_W - 9)), 32'(ew >> (WORD_W - 9)));
        repeat (MONO_CYC / 2) @(negedge clk);
        chk("R6 held level", 32'(ssi_data), 32'(ew[WORD_W-9]));
        wait_idle("R6");

        // R6: paused burst resumes within the interval
        pos_in = 17'h0C3A5; gray_en = 1'b1;
        burst(WORD_W + 1, 6, 400, got);
        chk("R6 resumed word", 32'(got), 32'(exp_word(17'h0C3A5, 1'b1)));
        wait_idle("R6 resumed");

        // R7: overclocked burst
        cur_tag = "R7";
        pos_in = 17'h05A5A; gray_en = 1'b0;
        burst(WORD_W + 6, 0, 0, got);
        chk("R7 word intact", 32'(got), 32'(exp_word(17'h05A5A, 1'b0)));
        chk("R7 busy during tail", 32'(busy), 32'd1);
        wait_idle("R7");

        // R10: falling edge lands on the expiry cycle
        cur_tag = "R10";
        pos_in = 17'h00F0F; gray_en = 1'b0;
        burst(WORD_W + 1, 0, 0, got);
        while (cyc < last_fall + MONO_CYC) @(negedge clk);
        ssi_clk = 1'b0; last_fall = cyc;
        repeat (6) @(negedge clk);
        chk("R10 still busy", 32'(busy), 32'd1);
        chk("R10 still low", 32'(ssi_data), 32'd0);
        ssi_clk = 1'b1;
        wait_idle("R10");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule